// File: doc/BRIEF.md
# RTC Interrupt and Alarm Unit

This block produces the three interrupt flags of a real-time clock and its active-low interrupt request. It watches three sources. The first is a periodic tick, taken from a divider tap that a rate code selects. The second is the update-ended strobe of the timekeeper. The third is the current hours, minutes and seconds bytes. It holds three alarm bytes, and on each update strobe it compares them with the time. An alarm byte whose two upper bits are both set is a wildcard. Wildcards give alarms once per day, hour, minute or second.

Software reaches the block through a small register port. It writes the alarm bytes and a control byte that holds the rate code, three enables and a transfer-inhibit bit. It reads a flag byte, and reading that byte with the read strobe clears it. Each flag is set whether or not its enable is set. Only enabled flags assert the interrupt request.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset the alarm bytes, the control byte and all flags read as 0, and `irq_n` is 1.
- R2: With rate code k (control bits [3:0]) nonzero, a 0-to-1 change of `div_taps[k-1]` between two clock edges sets the periodic flag, bit 0 of address 4, at that edge. A rate code of 0 never sets the periodic flag.
- R3: The periodic flag drives `irq_n` low only while the periodic enable (control bit 4) is 1.
- R4: At an edge where `upd_done` is 1, the alarm flag (bit 1 of address 4) is set if every non-wildcard alarm byte equals its time byte. This happens whatever the value of the alarm enable. Alarm bytes are at address 0 (seconds), 1 (minutes) and 2 (hours).
- R5: An alarm byte with bits [7:6] equal to 2'b11 matches any time byte. A byte without that pattern must match exactly.
- R6: The alarm flag drives `irq_n` low only while the alarm enable (control bit 5) is 1.
- R7: Every edge with `upd_done` at 1 sets the update flag (bit 2 of address 4). That flag drives `irq_n` low only while the update enable (control bit 6) is 1 and the transfer-inhibit bit (control bit 7) is 0.
- R8: Address 4 returns the flags and, in bit 7, the summary interrupt bit. A read strobe at address 4 clears all flags at that edge, except a flag whose event arrives at the same edge, which stays set.
- R9: `irq_n` is the inverse of the summary bit, which is the OR of each flag ANDed with its effective enable.
- R10: Writing the alarm bytes or writing address 4 leaves the flags unchanged.
- R11: Addresses 0 to 3 read back the last value written, and addresses 5 to 7 read as 0. `rdata` follows `addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_taps | input | 15 | Divider taps, one per nonzero rate code |
| upd_done | input | 1 | Update-ended strobe, one cycle |
| cur_hr | input | 8 | Current hours byte |
| cur_min | input | 8 | Current minutes byte |
| cur_sec | input | 8 | Current seconds byte |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags at address 4) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Each event is driven half a period before an edge. The matching flag appears after that one edge, and `irq_n` and the flag byte change with it. `rdata` depends on `addr` alone within the same cycle. For this reason the bench drives every input on the falling edge and samples one time unit later. At that point it compares against a model that has advanced once per rising edge. Directed cases pin down the wildcard patterns, the enable gating, set-over-clear collisions and writes that must leave the flags untouched. Seeded random traffic then mixes all the sources.

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit #(
  parameter int DW     = 8,
  parameter int RATE_W = 4,
  parameter int AW     = 3,
  parameter int NTAPS  = (1 << RATE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NTAPS-1:0]  div_taps,
  input  logic              upd_done,
  input  logic [DW-1:0]     cur_hr,
  input  logic [DW-1:0]     cur_min,
  input  logic [DW-1:0]     cur_sec,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq_n
);
  localparam logic [AW-1:0] A_CTL = AW'(3);
  localparam logic [AW-1:0] A_FLG = AW'(4);
  localparam int B_PIE = RATE_W;
  localparam int B_AIE = RATE_W + 1;
  localparam int B_UIE = RATE_W + 2;
  localparam int B_INH = RATE_W + 3;

  logic [2:0][DW-1:0] alm_q;
  logic [2:0][DW-1:0] cur;
  logic [DW-1:0]      ctrl_q;
  logic [2:0]         flag_q;
  logic [NTAPS-1:0]   taps_q;

  logic [RATE_W-1:0] rate, idx;
  logic              per_evt, alm_hit, clr, irq_any;
  logic [2:0]        byte_ok, en, set;

  assign cur  = {cur_hr, cur_min, cur_sec};
  assign rate = ctrl_q[RATE_W-1:0];
  assign idx  = rate - 1'b1;
  assign per_evt = (rate != '0) && div_taps[idx] && !taps_q[idx];

  for (genvar i = 0; i < 3; i++) begin : g_cmp
    assign byte_ok[i] = (&alm_q[i][DW-1:DW-2]) || (alm_q[i] == cur[i]);
  end

  assign alm_hit = upd_done && (&byte_ok);
  assign set     = {upd_done, alm_hit, per_evt};
  assign clr     = rd_en && (addr == A_FLG);
  assign en      = {ctrl_q[B_UIE] & ~ctrl_q[B_INH], ctrl_q[B_AIE], ctrl_q[B_PIE]};
  assign irq_any = |(flag_q & en);
  assign irq_n   = ~irq_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_q  <= '0;
      ctrl_q <= '0;
      flag_q <= '0;
      taps_q <= '0;
    end else begin
      taps_q <= div_taps;
      flag_q <= set | (clr ? 3'b000 : flag_q);
      if (wr_en) begin
        if (addr < A_CTL) alm_q[addr[1:0]] <= wdata;
        else if (addr == A_CTL) ctrl_q <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr < A_CTL)       rdata = alm_q[addr[1:0]];
    else if (addr == A_CTL) rdata = ctrl_q;
    else if (addr == A_FLG) rdata = {irq_any, {(DW-4){1'b0}}, flag_q};
  end
endmodule

// File: rtl/rtc_irq_unit_chk.sv
module rtc_irq_unit_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_done,
  input logic              wr_en,
  input logic              rd_en,
  input logic [AW-1:0]     addr,
  input logic              irq_n,
  input logic [2:0]        flag_q,
  input logic [DW-1:0]     ctrl_q,
  input logic [2:0][DW-1:0] alm_q
);
  // R7
  upd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> flag_q[2]);

  // R8
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(4) && !upd_done) |=> !flag_q[2]);

  // R5
  wild_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && (&alm_q)) |=> flag_q[1]);

  // R10
  alm_wr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr < AW'(3) && flag_q[1]) |=> flag_q[1]);

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flag_q != 3'b000));

  // R7
  inh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] && !ctrl_q[4] && !ctrl_q[5]) |-> irq_n);
endmodule

bind rtc_irq_unit rtc_irq_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_done(upd_done), .wr_en(wr_en),
  .rd_en(rd_en), .addr(addr), .irq_n(irq_n), .flag_q(flag_q),
  .ctrl_q(ctrl_q), .alm_q(alm_q)
);

// File: tb/tb_rtc_irq_unit.sv
module tb_rtc_irq_unit;
  logic clk = 0, rst_n = 0;
  logic [14:0] div_taps;
  logic upd_done, wr_en, rd_en;
  logic [7:0] cur_hr, cur_min, cur_sec, wdata, rdata;
  logic [2:0] addr;
  logic irq_n;

  rtc_irq_unit dut (.*);

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [14:0] d_taps = '0;
  logic d_upd = 0, d_wr = 0, d_rd = 0;
  logic [7:0] d_h = 0, d_m = 0, d_s = 0, d_wd = 0, last_rd;
  logic [2:0] d_addr = 0;
  logic last_irq;

  logic [7:0] m_alm [3];
  logic [7:0] m_ctl = 0;
  logic [2:0] m_flg = 0;
  logic [14:0] m_tq = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_sum();
    return |(m_flg & {m_ctl[6] & ~m_ctl[7], m_ctl[5], m_ctl[4]});
  endfunction

  function automatic logic [7:0] m_read(logic [2:0] a);
    if (a < 3) return m_alm[a];
    if (a == 3) return m_ctl;
    if (a == 4) return {m_sum(), 4'b0, m_flg};
    return 8'h00;
  endfunction

  function automatic logic m_ok(logic [7:0] al, logic [7:0] t);
    return (al[7:6] == 2'b11) || (al == t);
  endfunction

  task automatic cyc();
    logic [3:0] r;
    logic pe, hit, clr;
    @(negedge clk);
    div_taps = d_taps; upd_done = d_upd; cur_hr = d_h; cur_min = d_m; cur_sec = d_s;
    wr_en = d_wr; rd_en = d_rd; addr = d_addr; wdata = d_wd;
    #1;
    last_rd = rdata; last_irq = irq_n;
    if (rst_n) begin
      chk(d_addr == 4 ? "R8" : "R11", rdata, m_read(d_addr));
      chk("R9", irq_n, !m_sum());
      r = m_ctl[3:0];
      pe = (r != 0) && d_taps[r-1] && !m_tq[r-1];
      hit = d_upd && m_ok(m_alm[0], d_s) && m_ok(m_alm[1], d_m) && m_ok(m_alm[2], d_h);
      clr = d_rd && d_addr == 4;
      m_flg = {d_upd, hit, pe} | (clr ? 3'b000 : m_flg);
      if (d_wr && d_addr < 3) m_alm[d_addr] = d_wd;
      else if (d_wr && d_addr == 3) m_ctl = d_wd;
      m_tq = d_taps;
    end
    @(posedge clk);
    d_wr = 0; d_rd = 0; d_upd = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] v);
    d_wr = 1; d_addr = a; d_wd = v; cyc();
  endtask

  task automatic peek(logic [2:0] a);
    d_addr = a; cyc();
  endtask

  task automatic rdclr();
    d_addr = 4; d_rd = 1; cyc();
  endtask

  task automatic upd(logic [7:0] h, logic [7:0] m, logic [7:0] s);
    d_h = h; d_m = m; d_s = s; d_upd = 1; cyc();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) m_alm[i] = 0;
    void'($urandom(32'd24680));
    repeat (3) cyc();
    rst_n = 1;
    for (int a = 0; a < 5; a++) begin
      peek(3'(a));
      chk("R1", last_rd, 0);
    end
    chk("R1", last_irq, 1);

    wr(3, 8'h03); d_taps = 15'h0000; cyc();
    d_taps = 15'h0004; cyc();
    peek(4); chk("R2", last_rd, 8'h01); chk("R3", last_irq, 1);
    wr(3, 8'h13); peek(4); chk("R3", last_irq, 0); chk("R3", last_rd, 8'h81);
    rdclr(); chk("R8", last_rd, 8'h81);
    peek(4); chk("R8", last_rd, 8'h00); chk("R8", last_irq, 1);
    wr(3, 8'h10); d_taps = 15'h0000; cyc(); d_taps = 15'h7FFF; cyc();
    peek(4); chk("R2", last_rd, 8'h00);
    d_taps = 15'h0000; cyc();

    wr(3, 8'h00); wr(0, 8'h15); wr(1, 8'h30); wr(2, 8'hC0);
    upd(8'h07, 8'h30, 8'h15);
    peek(4); chk("R4", last_rd, 8'h06); chk("R6", last_irq, 1);
    wr(3, 8'h20); peek(4); chk("R6", last_rd, 8'h86); chk("R6", last_irq, 0);
    wr(0, 8'h44); peek(4); chk("R10", last_rd, 8'h86);
    wr(4, 8'h00); peek(4); chk("R10", last_rd, 8'h86);
    wr(0, 8'h15); rdclr();
    upd(8'h07, 8'h31, 8'h15); peek(4); chk("R5", last_rd, 8'h04); rdclr();
    wr(2, 8'h07);
    upd(8'h08, 8'h30, 8'h15); peek(4); chk("R5", last_rd, 8'h04); rdclr();
    upd(8'h07, 8'h30, 8'h15); peek(4); chk("R4", last_rd, 8'h86); rdclr();
    wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF);
    upd(8'h23, 8'h59, 8'h42); peek(4); chk("R5", last_rd, 8'h86); rdclr();

    wr(3, 8'hC0); upd(8'h01, 8'h02, 8'h03);
    peek(4); chk("R7", last_rd, 8'h06); chk("R7", last_irq, 1);
    wr(3, 8'h40); peek(4); chk("R7", last_rd, 8'h86); chk("R7", last_irq, 0);
    d_addr = 4; d_rd = 1; d_upd = 1; cyc(); chk("R8", last_rd, 8'h86);
    peek(4); chk("R8", last_rd, 8'h86);
    peek(5); chk("R11", last_rd, 8'h00);
    wr(1, 8'h5A); peek(1); chk("R11", last_rd, 8'h5A);

    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 3 == 0) d_taps = d_taps ^ (15'd1 << ($urandom % 15));
      d_upd = ($urandom % 6) == 0;
      d_h = ($urandom % 2) ? m_alm[2] : 8'($urandom % 24);
      d_m = ($urandom % 2) ? m_alm[1] : 8'($urandom % 60);
      d_s = ($urandom % 2) ? m_alm[0] : 8'($urandom % 60);
      d_rd = ($urandom % 5) == 0;
      d_wr = ($urandom % 9) == 0;
      d_addr = 3'($urandom % 6);
      d_wd = 8'($urandom);
      if (d_addr < 3 && ($urandom % 3 == 0)) d_wd = d_wd | 8'hC0;
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule